// File: doc/BRIEF.md
# Cascaded Reset Sequencer

This block sequences a chip through five reset levels. From most to least severe they are power-on, brownout, boot, system and CPU-only. Each level has its own set of triggers: supply and brownout flags, a shutdown-exit event, software request strobes, the watchdog, the debug subsystem, bootloader entry or exit, a fatal clock failure, and the external active-low reset pin. When any level starts, the block also runs every less severe level in turn. Each level is held for a minimum number of cycles before the next one starts. When the chain finishes, the block raises its RUN indication.

There is one active-high reset output per domain: shutdown memory, power unit and core supply, RTC with its low-speed clock, boot logic, peripherals, and CPU. The block also keeps a cause record. It holds the most severe level seen since the last read and the source that raised it, and a read clears it. The reset pin is synchronized and debounced. Its low time is measured with a saturating counter, so that a short press can be told apart from a press held for the long threshold. The boot step itself lies outside the block and answers through a done input. Analog threshold detection is also outside and appears here only as flags.

Top module: `rstCascade`

## Requirements
- R1: Output bit order {rstShutMem, rstPowerCore, rstRtc, rstBoot, rstPeriph, rstCpu}. Each level drives a fixed pattern on these outputs: power-on 111111, brownout 011111, boot 001111, system 000011, CPU-only 000001, RUN 000000. Level codes are power-on 0, brownout 1, boot 2, system 3, CPU-only 4, RUN 5.
- R2: Each level lasts HOLD_CYCLES cycles, counting the cycle it was entered, and then steps to the next less severe level. CPU-only steps to RUN. The boot level also waits for bootDone to be high before it steps.
- R3: Trigger map. Power-on: swPorReq, or the long pin release. Brownout: brownFlag when borAsReset=1, or shutdownExit. Boot: swBootReq, clkFail, or the debounced pin being low. System: bslEvent, wdtExpire, swSysReq, dbgSysReq. CPU-only: swCpuReq, dbgCpuReq.
- R4: The system and CPU-only levels never assert rstRtc, rstBoot or rstPowerCore. rstRtc is asserted only at boot level or above.
- R5: A trigger of equal or greater severity than the current level restarts the sequence at its own level. A less severe trigger that arrives during sequencing has no effect on the outputs or on the cause record.
- R6: When borAsReset=0, brownFlag raises brownIrq and causes no reset. When borAsReset=1, brownIrq stays low.
- R7: pinN is synchronized and must hold a new value for DEB_CYCLES samples before it is accepted. A shorter glitch has no effect. A debounced low holds boot level. If the low lasted at least CLK_HZ/1000*LONG_MS cycles, its release starts the power-on level.
- R8: The cause record (causeLevel, causeSrc) keeps the most severe accepted trigger since the last read. A later trigger replaces it only if it is strictly more severe. Source codes: none 0, supply 1, software power-on 2, long pin 3, brownout 4, shutdown exit 5, software boot 6, clock fail 7, pin low 8, bootloader 9, watchdog 10, software system 11, debug system 12, software CPU 13, debug CPU 14. A causeRead pulse empties the record to level 5, source 0 in the next cycle.
- R9: runMode is high exactly when no reset output is asserted.
- R10: supplyLow is an asynchronous power-on input. While it is high, every reset output is asserted. After it falls, the power-on sequence runs and the cause record reads level 0, source 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supplyLow | input | 1 | Asynchronous power-not-good flag |
| brownFlag | input | 1 | Brownout monitor flag |
| borAsReset | input | 1 | 1: brownout resets, 0: brownout interrupts |
| shutdownExit | input | 1 | Leaving shutdown mode |
| swPorReq | input | 1 | Software power-on request |
| swBootReq | input | 1 | Software boot request |
| swSysReq | input | 1 | Software system request |
| swCpuReq | input | 1 | Software CPU request |
| clkFail | input | 1 | Fatal clock failure |
| wdtExpire | input | 1 | Watchdog expiry |
| dbgSysReq | input | 1 | Debug system request |
| dbgCpuReq | input | 1 | Debug CPU request |
| bslEvent | input | 1 | Bootloader entry or exit |
| pinN | input | 1 | External reset pin, active low |
| bootDone | input | 1 | Boot step finished |
| causeRead | input | 1 | Read strobe that clears the cause record |
| rstShutMem | output | 1 | Shutdown memory reset |
| rstPowerCore | output | 1 | Power unit and core supply reset |
| rstRtc | output | 1 | RTC and low-speed clock reset |
| rstBoot | output | 1 | Boot logic reset |
| rstPeriph | output | 1 | Peripheral reset |
| rstCpu | output | 1 | CPU reset |
| runMode | output | 1 | Device released into RUN |
| brownIrq | output | 1 | Brownout interrupt |
| causeLevel | output | 3 | Recorded most severe level |
| causeSrc | output | 4 | Recorded trigger source |

## Verification
The reset outputs are decoded directly from the level register. A wrong level is therefore visible on the six outputs in the first cycle after the edge that loads it. A nesting violation, such as the RTC reset without the peripheral reset, shows up at once. A hold counter that is off by one moves each step edge by a cycle, and that shift accumulates along the chain. The bench samples every fourth cycle of a full power-on run, so a drift of even one cycle is caught at the first level boundary. A cause record that is overwritten wrongly stays hidden until the record is read. The bench therefore reads it after each sequence and after deliberate pairs of mixed-severity triggers.

// File: rtl/rstCascadePkg.sv
package rstCascadePkg;
  typedef enum logic [2:0] {
    LV_POR  = 3'd0,
    LV_BOR  = 3'd1,
    LV_BOOT = 3'd2,
    LV_SYS  = 3'd3,
    LV_CPU  = 3'd4,
    LV_RUN  = 3'd5
  } lvl_e;

  typedef enum logic [3:0] {
    SRC_NONE     = 4'd0,
    SRC_SUPPLY   = 4'd1,
    SRC_SW_POR   = 4'd2,
    SRC_PIN_LONG = 4'd3,
    SRC_BROWN    = 4'd4,
    SRC_SHUTDOWN = 4'd5,
    SRC_SW_BOOT  = 4'd6,
    SRC_CLK_FAIL = 4'd7,
    SRC_PIN_LOW  = 4'd8,
    SRC_BSL      = 4'd9,
    SRC_WDT      = 4'd10,
    SRC_SW_SYS   = 4'd11,
    SRC_DBG_SYS  = 4'd12,
    SRC_SW_CPU   = 4'd13,
    SRC_DBG_CPU  = 4'd14
  } src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdClr;
    logic causeLoad;
  } ctlStb_t;
endpackage

// File: rtl/rstDatapath.sv
module rstDatapath
  import rstCascadePkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int DEB_CYCLES  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_CYCLES = 1000
) (
  input  logic    clk,
  input  logic    supplyLow,
  input  logic    pinN,
  input  logic    brownFlag,
  input  logic    borAsReset,
  input  logic    shutdownExit,
  input  logic    swPorReq,
  input  logic    swBootReq,
  input  logic    swSysReq,
  input  logic    swCpuReq,
  input  logic    clkFail,
  input  logic    wdtExpire,
  input  logic    dbgSysReq,
  input  logic    dbgCpuReq,
  input  logic    bslEvent,
  input  logic    causeRead,
  input  ctlStb_t stb,
  output logic    reqAny,
  output lvl_e    reqLvl,
  output logic    holdDone,
  output lvl_e    causeLevel,
  output src_e    causeSrc
);
  localparam int HCW = $clog2(HOLD_CYCLES + 1);
  localparam int DCW = $clog2(DEB_CYCLES + 1);
  localparam int LCW = $clog2(LONG_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DCW-1:0] debCnt;
  logic [LCW-1:0] lowCnt;
  logic [HCW-1:0] holdCnt;
  logic pinStable, pinPrev, pinRise, pinLongRel;
  src_e reqSrc;

  // synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or posedge supplyLow) begin
        if (supplyLow) syncQ[s] <= 1'b1;
        else if (s == 0) syncQ[s] <= pinN;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // debounce and low-time measurement
  always_ff @(posedge clk or posedge supplyLow) begin
    if (supplyLow) begin
      debCnt    <= '0;
      pinStable <= 1'b1;
      pinPrev   <= 1'b1;
      lowCnt    <= '0;
    end else begin
      pinPrev <= pinStable;
      if (syncQ[SYNC_STAGES-1] == pinStable) debCnt <= '0;
      else if (debCnt == DCW'(DEB_CYCLES - 1)) begin
        debCnt    <= '0;
        pinStable <= syncQ[SYNC_STAGES-1];
      end else debCnt <= debCnt + 1'b1;
      if (!pinStable) begin
        if (lowCnt != LCW'(LONG_CYCLES)) lowCnt <= lowCnt + 1'b1;
      end else if (pinPrev) lowCnt <= '0;
    end
  end

  assign pinRise    = pinStable & ~pinPrev;
  assign pinLongRel = pinRise && (lowCnt >= LCW'(LONG_CYCLES));

  // most severe pending trigger
  always_comb begin
    reqAny = 1'b1;
    reqLvl = LV_RUN;
    reqSrc = SRC_NONE;
    if (swPorReq)                     begin reqLvl = LV_POR;  reqSrc = SRC_SW_POR;   end
    else if (pinLongRel)              begin reqLvl = LV_POR;  reqSrc = SRC_PIN_LONG; end
    else if (brownFlag && borAsReset) begin reqLvl = LV_BOR;  reqSrc = SRC_BROWN;    end
    else if (shutdownExit)            begin reqLvl = LV_BOR;  reqSrc = SRC_SHUTDOWN; end
    else if (swBootReq)               begin reqLvl = LV_BOOT; reqSrc = SRC_SW_BOOT;  end
    else if (clkFail)                 begin reqLvl = LV_BOOT; reqSrc = SRC_CLK_FAIL; end
    else if (!pinStable)              begin reqLvl = LV_BOOT; reqSrc = SRC_PIN_LOW;  end
    else if (bslEvent)                begin reqLvl = LV_SYS;  reqSrc = SRC_BSL;      end
    else if (wdtExpire)               begin reqLvl = LV_SYS;  reqSrc = SRC_WDT;      end
    else if (swSysReq)                begin reqLvl = LV_SYS;  reqSrc = SRC_SW_SYS;   end
    else if (dbgSysReq)               begin reqLvl = LV_SYS;  reqSrc = SRC_DBG_SYS;  end
    else if (swCpuReq)                begin reqLvl = LV_CPU;  reqSrc = SRC_SW_CPU;   end
    else if (dbgCpuReq)               begin reqLvl = LV_CPU;  reqSrc = SRC_DBG_CPU;  end
    else reqAny = 1'b0;
  end

  // per-level minimum hold
  always_ff @(posedge clk or posedge supplyLow) begin
    if (supplyLow) holdCnt <= '0;
    else if (stb.holdClr) holdCnt <= '0;
    else if (!holdDone) holdCnt <= holdCnt + 1'b1;
  end
  assign holdDone = (holdCnt == HCW'(HOLD_CYCLES - 1));

  // cause record: keeps most severe since last read
  always_ff @(posedge clk or posedge supplyLow) begin
    if (supplyLow) begin
      causeLevel <= LV_POR;
      causeSrc   <= SRC_SUPPLY;
    end else if (stb.causeLoad &&
                 (causeRead || causeSrc == SRC_NONE || reqLvl < causeLevel)) begin
      causeLevel <= reqLvl;
      causeSrc   <= reqSrc;
    end else if (causeRead) begin
      causeLevel <= LV_RUN;
      causeSrc   <= SRC_NONE;
    end
  end
endmodule

// File: rtl/rstControl.sv
module rstControl
  import rstCascadePkg::*;
(
  input  logic    clk,
  input  logic    supplyLow,
  input  logic    reqAny,
  input  lvl_e    reqLvl,
  input  logic    holdDone,
  input  logic    bootDone,
  output ctlStb_t stb,
  output lvl_e    curLvl
);
  logic jump, step;
  lvl_e nextLvl;

  always_comb begin
    jump = reqAny && (reqLvl <= curLvl);
    step = !jump && (curLvl != LV_RUN) && holdDone &&
           ((curLvl != LV_BOOT) || bootDone);
    if (jump) nextLvl = reqLvl;
    else if (step) nextLvl = lvl_e'(curLvl + 3'd1);
    else nextLvl = curLvl;
    stb.holdClr   = jump || step;
    stb.causeLoad = jump;
  end

  always_ff @(posedge clk or posedge supplyLow) begin
    if (supplyLow) curLvl <= LV_POR;
    else curLvl <= nextLvl;
  end
endmodule

// File: rtl/rstCascade.sv
module rstCascade
  import rstCascadePkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int DEB_CYCLES  = 4,
  parameter int CLK_HZ      = 32000000,
  parameter int LONG_MS     = 1000
) (
  input  logic       clk,
  input  logic       supplyLow,
  input  logic       brownFlag,
  input  logic       borAsReset,
  input  logic       shutdownExit,
  input  logic       swPorReq,
  input  logic       swBootReq,
  input  logic       swSysReq,
  input  logic       swCpuReq,
  input  logic       clkFail,
  input  logic       wdtExpire,
  input  logic       dbgSysReq,
  input  logic       dbgCpuReq,
  input  logic       bslEvent,
  input  logic       pinN,
  input  logic       bootDone,
  input  logic       causeRead,
  output logic       rstShutMem,
  output logic       rstPowerCore,
  output logic       rstRtc,
  output logic       rstBoot,
  output logic       rstPeriph,
  output logic       rstCpu,
  output logic       runMode,
  output logic       brownIrq,
  output logic [2:0] causeLevel,
  output logic [3:0] causeSrc
);
  localparam int LONG_CYCLES = CLK_HZ / 1000 * LONG_MS;

  ctlStb_t stb;
  logic reqAny, holdDone;
  lvl_e reqLvl, curLvl, causeLvlQ;
  src_e causeSrcQ;

  rstDatapath #(
    .HOLD_CYCLES(HOLD_CYCLES), .DEB_CYCLES(DEB_CYCLES),
    .SYNC_STAGES(2), .LONG_CYCLES(LONG_CYCLES)
  ) dp_i (
    .clk(clk), .supplyLow(supplyLow), .pinN(pinN), .brownFlag(brownFlag),
    .borAsReset(borAsReset), .shutdownExit(shutdownExit), .swPorReq(swPorReq),
    .swBootReq(swBootReq), .swSysReq(swSysReq), .swCpuReq(swCpuReq),
    .clkFail(clkFail), .wdtExpire(wdtExpire), .dbgSysReq(dbgSysReq),
    .dbgCpuReq(dbgCpuReq), .bslEvent(bslEvent), .causeRead(causeRead),
    .stb(stb), .reqAny(reqAny), .reqLvl(reqLvl), .holdDone(holdDone),
    .causeLevel(causeLvlQ), .causeSrc(causeSrcQ)
  );

  rstControl ctl_i (
    .clk(clk), .supplyLow(supplyLow), .reqAny(reqAny), .reqLvl(reqLvl),
    .holdDone(holdDone), .bootDone(bootDone), .stb(stb), .curLvl(curLvl)
  );

  // domain decode: a level resets its own domain and every lesser one
  assign rstShutMem   = supplyLow || (curLvl <= LV_POR);
  assign rstPowerCore = supplyLow || (curLvl <= LV_BOR);
  assign rstRtc       = supplyLow || (curLvl <= LV_BOOT);
  assign rstBoot      = supplyLow || (curLvl <= LV_BOOT);
  assign rstPeriph    = supplyLow || (curLvl <= LV_SYS);
  assign rstCpu       = supplyLow || (curLvl <= LV_CPU);
  assign runMode      = !supplyLow && (curLvl == LV_RUN);
  assign brownIrq     = brownFlag && !borAsReset;
  assign causeLevel   = causeLvlQ;
  assign causeSrc     = causeSrcQ;
endmodule

// File: rtl/rstCascadeChecker.sv
module rstCascadeChecker (
  input logic       clk,
  input logic       supplyLow,
  input logic       bootDone,
  input logic       causeRead,
  input logic       borAsReset,
  input logic       brownIrq,
  input logic       rstShutMem,
  input logic       rstPowerCore,
  input logic       rstRtc,
  input logic       rstBoot,
  input logic       rstPeriph,
  input logic       rstCpu,
  input logic       runMode,
  input logic [2:0] causeLevel,
  input logic [3:0] causeSrc
);
  a_r1_nesting: assert property (@(posedge clk) disable iff (supplyLow)
    (rstShutMem |-> rstPowerCore) and (rstPowerCore |-> rstRtc) and
    (rstBoot |-> rstPeriph) and (rstPeriph |-> rstCpu));

  a_r4_rtc_with_boot: assert property (@(posedge clk) disable iff (supplyLow)
    (rstPeriph && !rstBoot) |-> (!rstRtc && !rstPowerCore));

  a_r2_boot_waits: assert property (@(posedge clk) disable iff (supplyLow)
    $fell(rstBoot) |-> $past(bootDone));

  a_r2_order: assert property (@(posedge clk) disable iff (supplyLow)
    $fell(rstPowerCore) |-> rstBoot);

  a_r9_run_clean: assert property (@(posedge clk) disable iff (supplyLow)
    runMode |-> !(rstCpu || rstPeriph || rstBoot || rstRtc));

  a_r6_irq_mode: assert property (@(posedge clk) disable iff (supplyLow)
    borAsReset |-> !brownIrq);

  a_r8_cause_sticky: assert property (@(posedge clk) disable iff (supplyLow)
    (!causeRead && causeSrc != 4'd0) |=> (causeLevel <= $past(causeLevel)));
endmodule

bind rstCascade rstCascadeChecker chk_i (
  .clk(clk), .supplyLow(supplyLow), .bootDone(bootDone), .causeRead(causeRead),
  .borAsReset(borAsReset), .brownIrq(brownIrq), .rstShutMem(rstShutMem),
  .rstPowerCore(rstPowerCore), .rstRtc(rstRtc), .rstBoot(rstBoot),
  .rstPeriph(rstPeriph), .rstCpu(rstCpu), .runMode(runMode),
  .causeLevel(causeLevel), .causeSrc(causeSrc)
);

// File: tb/rstCascade_tb_top.sv
module rstCascade_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic supplyLow = 1'b1, brownFlag = 0, borAsReset = 1, shutdownExit = 0;
  logic swPorReq = 0, swBootReq = 0, swSysReq = 0, swCpuReq = 0;
  logic clkFail = 0, wdtExpire = 0, dbgSysReq = 0, dbgCpuReq = 0, bslEvent = 0;
  logic pinN = 1, bootDone = 1, causeRead = 0;
  logic rstShutMem, rstPowerCore, rstRtc, rstBoot, rstPeriph, rstCpu;
  logic runMode, brownIrq;
  logic [2:0] causeLevel;
  logic [3:0] causeSrc;

  int checks = 0, fails = 0;
  bit finished = 0;

  rstCascade #(.HOLD_CYCLES(4), .DEB_CYCLES(4), .CLK_HZ(100000), .LONG_MS(1)) dut_i (.*);

  wire [5:0] outs = {rstShutMem, rstPowerCore, rstRtc, rstBoot, rstPeriph, rstCpu};

  // {trigger source code[12:9], expected level[8:6], expected outputs[5:0]}
  localparam logic [12:0] VEC [0:10] = '{
    {4'd2,  3'd0, 6'b111111}, {4'd4,  3'd1, 6'b011111}, {4'd5,  3'd1, 6'b011111},
    {4'd6,  3'd2, 6'b001111}, {4'd7,  3'd2, 6'b001111}, {4'd9,  3'd3, 6'b000011},
    {4'd10, 3'd3, 6'b000011}, {4'd11, 3'd3, 6'b000011}, {4'd12, 3'd3, 6'b000011},
    {4'd13, 3'd4, 6'b000001}, {4'd14, 3'd4, 6'b000001}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setTrig(input int id, input logic v);
    case (id)
      2: swPorReq = v;   4: brownFlag = v;  5: shutdownExit = v;
      6: swBootReq = v;  7: clkFail = v;    9: bslEvent = v;
      10: wdtExpire = v; 11: swSysReq = v;  12: dbgSysReq = v;
      13: swCpuReq = v;  14: dbgCpuReq = v; default: ;
    endcase
  endtask

  // drive one-cycle pulse; returns at the negedge right after the accepting edge
  task automatic pulse(input int id);
    @(negedge clk); setTrig(id, 1'b1);
    @(negedge clk); setTrig(id, 1'b0);
  endtask

  task automatic waitRun();
    for (int i = 0; i < 300 && !runMode; i++) @(negedge clk);
  endtask

  task automatic readCause(input int lvl, input int src, input string req);
    chk(causeLevel == 3'(lvl) && causeSrc == 4'(src), req,
        {causeLevel, causeSrc}, {3'(lvl), 4'(src)});
    causeRead = 1'b1; @(negedge clk); causeRead = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: power-on state
    repeat (3) @(negedge clk);
    chk(outs == 6'b111111 && !runMode, "R10 reset state", outs, 6'b111111);
    supplyLow = 1'b0;
    waitRun();
    chk(runMode && outs == 6'b0, "R9 run after power-on", outs, 0);
    readCause(0, 1, "R10 cause supply");
    chk(causeLevel == 3'd5 && causeSrc == 4'd0, "R8 cleared on read",
        {causeLevel, causeSrc}, {3'd5, 4'd0});

    // table walk: R1 R3 R4 level patterns and cause sources
    for (int v = 0; v < 11; v++) begin
      pulse(int'(VEC[v][12:9]));
      chk(outs == VEC[v][5:0], "R1 R3 R4 entry pattern", outs, VEC[v][5:0]);
      waitRun();
      chk(runMode, "R2 reaches RUN", runMode, 1);
      readCause(int'(VEC[v][8:6]), int'(VEC[v][12:9]), "R8 cause per trigger");
    end

    // R2: full cascade timing, HOLD_CYCLES=4 per level
    pulse(2);
    chk(outs == 6'b111111, "R2 k0", outs, 6'b111111);
    repeat (4) @(negedge clk); chk(outs == 6'b011111, "R2 k4", outs, 6'b011111);
    repeat (4) @(negedge clk); chk(outs == 6'b001111, "R2 k8", outs, 6'b001111);
    repeat (4) @(negedge clk); chk(outs == 6'b000011, "R2 k12", outs, 6'b000011);
    repeat (4) @(negedge clk); chk(outs == 6'b000001, "R2 k16", outs, 6'b000001);
    repeat (3) @(negedge clk); chk(!runMode, "R2 k19 not yet run", runMode, 0);
    @(negedge clk); chk(runMode && outs == 0, "R2 k20 run", outs, 0);
    readCause(0, 2, "R8 after cascade");

    // R2: boot waits for bootDone
    bootDone = 1'b0;
    pulse(6);
    repeat (20) @(negedge clk);
    chk(outs == 6'b001111, "R2 boot held", outs, 6'b001111);
    bootDone = 1'b1;
    @(negedge clk);
    chk(outs == 6'b000011, "R2 boot released", outs, 6'b000011);
    waitRun(); readCause(2, 6, "R8 boot cause");

    // R5: more severe trigger preempts
    pulse(10);
    @(negedge clk); swBootReq = 1; @(negedge clk); swBootReq = 0;
    chk(outs == 6'b001111, "R5 preempt to boot", outs, 6'b001111);
    waitRun(); readCause(2, 6, "R5 cause upgraded");

    // R5: less severe trigger ignored during sequencing
    pulse(5);
    swCpuReq = 1; @(negedge clk); swCpuReq = 0;
    chk(outs == 6'b011111, "R5 lesser ignored", outs, 6'b011111);
    waitRun(); readCause(1, 5, "R5 cause unchanged");

    // R8: most severe kept across runs without read
    pulse(10); waitRun();
    pulse(13); waitRun();
    readCause(3, 10, "R8 keeps most severe");

    // R6: brownout as interrupt
    borAsReset = 0; brownFlag = 1;
    repeat (3) @(negedge clk);
    chk(brownIrq && runMode, "R6 interrupt mode", {brownIrq, runMode}, 3);
    brownFlag = 0; borAsReset = 1;
    @(negedge clk);
    chk(!brownIrq, "R6 irq clears", brownIrq, 0);

    // R7: glitch ignored
    pinN = 0; repeat (2) @(negedge clk); pinN = 1;
    repeat (10) @(negedge clk);
    chk(runMode, "R7 glitch ignored", runMode, 1);

    // R7: short press -> boot level
    pinN = 0; repeat (12) @(negedge clk);
    chk(outs == 6'b001111, "R7 pin held boot", outs, 6'b001111);
    repeat (8) @(negedge clk); pinN = 1;
    waitRun(); readCause(2, 8, "R7 short press cause");

    // R7: long press -> power-on on release
    pinN = 0; repeat (150) @(negedge clk); pinN = 1;
    for (int i = 0; i < 30 && !rstShutMem; i++) @(negedge clk);
    chk(rstShutMem, "R7 long press power-on", rstShutMem, 1);
    waitRun(); readCause(0, 3, "R7 long press cause");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule